// File: doc/BRIEF.md
# Delayed Read Target Responder

This block is the target-side half of a bridge's delayed read path, on the bus where the read starts. When a new read arrives, the block records the request in a single delayed-transaction slot and turns the initiator away with a target retry. The slot's contents go out on the `req_*` outputs so the far side of the bridge can run the read on the other bus.

The initiator keeps repeating the same read. The block serves a repeat only when three things hold: the far-side completion has finished, the completion data sits at the head of the read data queue, and ordering against posted writes is met. In that case it streams the queued data one word per clock and signals a disconnect with the final word.

A configuration bit lets the two cache-oriented memory read commands match a plain memory read slot. An initiator that quits early causes the remaining data to be dropped and the slot to be freed.

Top module: `drt_target`

## Requirements
- R1: In an address phase (`addr_valid`=1) carrying a read command while the slot is empty, the block captures the address, command and parity bit. Once the slot is written, these appear on `req_addr`, `req_cmd` and `req_par`. The read commands are 4'h2, 4'h6, 4'hA, 4'hC and 4'hE.
- R2: After such a capture, the byte enables are taken in the first cycle in which `irdy`=1. They appear on `req_be`, and `req_valid` rises at the next clock edge.
- R3: A captured request is answered by a one-cycle `retry` in the cycle after the byte enables are taken. `trdy` stays 0 during the capture and during the retry.
- R4: A repeat that matches the slot is served only if `cpl_done`, `rdq_head_ok` and `order_ok` are all 1 during its address phase. Otherwise it gets `retry` in the next cycle.
- R5: With `alias_en`=1, commands 4'hC and 4'hE count as 4'h6 on both sides of the comparison. With `alias_en`=0, the command must match exactly.
- R6: `disc` is 1 in the same cycle as the transfer of the word flagged by `rdq_last`. After that transfer the slot is empty.
- R7: If `init_abort` is asserted during streaming before the last word has transferred, `rdq_flush` pulses in that cycle and the slot is empty afterwards.
- R8: A repeat whose address, or command after aliasing, differs from the slot receives `retry`. The slot contents do not change.
- R9: Only one request is held. A different read arriving while the slot is full is retried and is not captured.
- R10: While serving, `trdy` equals `irdy`. One word moves on each cycle with `irdy`=1 (`rdq_pop`=1, `dout`=`rdq_data`), and cycles with `irdy`=0 are wait cycles.
- R11: An address phase with a non-read command produces no `retry`, no `trdy` and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address phase strobe |
| addr_in | input | AW | Transaction address |
| cmd_in | input | 4 | Bus command |
| par_in | input | 1 | Address parity bit |
| irdy | input | 1 | Initiator ready (active high) |
| be_in | input | DW/8 | First data phase byte enables |
| init_abort | input | 1 | Initiator ends the transaction |
| cpl_done | input | 1 | Far-side completion finished |
| rdq_head_ok | input | 1 | Completion data is at queue head |
| rdq_data | input | DW | Read data queue head word |
| rdq_last | input | 1 | Head word is the final one |
| order_ok | input | 1 | Posted-write ordering satisfied |
| alias_en | input | 1 | Memory read command aliasing enable |
| req_valid | output | 1 | Slot holds a request |
| req_addr | output | AW | Stored address |
| req_cmd | output | 4 | Stored command |
| req_par | output | 1 | Stored parity |
| req_be | output | DW/8 | Stored byte enables |
| retry | output | 1 | Target retry |
| trdy | output | 1 | Target ready, word transferred |
| disc | output | 1 | Disconnect with this word |
| dout | output | DW | Read data to initiator |
| rdq_pop | output | 1 | Consume queue head |
| rdq_flush | output | 1 | Discard remaining queue data |

## Verification
The bench builds the block with AW=16 and DW=64. The 64-bit data width makes the byte-enable field eight bits wide, so a byte-enable value that would be cut off by a narrower default becomes observable when it returns on `req_be`. The 16-bit address keeps mismatched and matching addresses easy to tell apart in the vector table, where every combination of readiness flags, aliasing and command pairs is paired with an expected serve-or-retry outcome.

// File: rtl/drt_pkg.sv
package drt_pkg;

    localparam logic [3:0] CMD_IO_RD       = 4'h2;
    localparam logic [3:0] CMD_MEM_RD      = 4'h6;
    localparam logic [3:0] CMD_CFG_RD      = 4'hA;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_BE    = 2'd1,
        BUS_RETRY = 2'd2,
        BUS_XFER  = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic [3:0] cmd;
        logic       par;
    } cmd_tag_t;

    function automatic logic is_read_cmd(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_MEM_RD) || (c == CMD_CFG_RD) ||
               (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
    endfunction

    function automatic logic [3:0] canon_cmd(input logic [3:0] c, input logic alias_on);
        if (alias_on && ((c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE)))
            return CMD_MEM_RD;
        return c;
    endfunction

endpackage

// File: rtl/drt_cmd_match.sv
module drt_cmd_match
    import drt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          entry_vld,
    input  logic [AW-1:0] e_addr,
    input  logic [3:0]    e_cmd,
    input  logic [AW-1:0] q_addr,
    input  logic [3:0]    q_cmd,
    input  logic          alias_en,
    output logic          hit
);
    logic addr_eq;
    logic cmd_eq;

    always_comb begin
        addr_eq = (e_addr == q_addr);
        cmd_eq  = (canon_cmd(e_cmd, alias_en) == canon_cmd(q_cmd, alias_en));
        hit     = entry_vld && addr_eq && cmd_eq;
    end
endmodule

// File: rtl/drt_entry.sv
module drt_entry
    import drt_pkg::*;
#(
    parameter int AW  = 32,
    parameter int BEW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stage_en,
    input  logic [AW-1:0]  st_addr,
    input  cmd_tag_t       st_tag,
    input  logic           commit,
    input  logic [BEW-1:0] commit_be,
    input  logic           free_en,
    output logic           vld,
    output logic [AW-1:0]  e_addr,
    output cmd_tag_t       e_tag,
    output logic [BEW-1:0] e_be
);
    logic [AW-1:0] stg_addr;
    cmd_tag_t      stg_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_addr <= '0;
            stg_tag  <= '0;
        end else if (stage_en) begin
            stg_addr <= st_addr;
            stg_tag  <= st_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= 1'b0;
            e_addr <= '0;
            e_tag  <= '0;
            e_be   <= '0;
        end else if (commit) begin
            vld    <= 1'b1;
            e_addr <= stg_addr;
            e_tag  <= stg_tag;
            e_be   <= commit_be;
        end else if (free_en) begin
            vld    <= 1'b0;
        end
    end
endmodule

// File: rtl/drt_bus_fsm.sv
module drt_bus_fsm
    import drt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_valid,
    input  logic cmd_is_read,
    input  logic entry_vld,
    input  logic hit,
    input  logic ready_all,
    input  logic irdy,
    input  logic init_abort,
    input  logic rdq_last,
    output logic stage_en,
    output logic commit,
    output logic free_en,
    output logic retry,
    output logic trdy,
    output logic disc,
    output logic flush
);
    bus_state_e st;
    bus_state_e nxt;

    always_comb begin
        nxt      = st;
        stage_en = 1'b0;
        commit   = 1'b0;
        trdy     = (st == BUS_XFER) && irdy;
        disc     = trdy && rdq_last;
        flush    = (st == BUS_XFER) && init_abort && !disc;
        free_en  = disc || flush;
        retry    = (st == BUS_RETRY);
        unique case (st)
            BUS_IDLE: begin
                if (addr_valid && cmd_is_read) begin
                    if (!entry_vld) begin
                        stage_en = 1'b1;
                        nxt      = BUS_BE;
                    end else if (hit && ready_all) begin
                        nxt = BUS_XFER;
                    end else begin
                        nxt = BUS_RETRY;
                    end
                end
            end
            BUS_BE: begin
                if (irdy) begin
                    commit = 1'b1;
                    nxt    = BUS_RETRY;
                end
            end
            BUS_RETRY: nxt = BUS_IDLE;
            BUS_XFER: begin
                if (disc || flush) nxt = BUS_IDLE;
            end
            default: nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= BUS_IDLE;
        else     st <= nxt;
    end
endmodule

// File: rtl/drt_target.sv
module drt_target
    import drt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           addr_valid,
    input  logic [AW-1:0]  addr_in,
    input  logic [3:0]     cmd_in,
    input  logic           par_in,
    input  logic           irdy,
    input  logic [BEW-1:0] be_in,
    input  logic           init_abort,
    input  logic           cpl_done,
    input  logic           rdq_head_ok,
    input  logic [DW-1:0]  rdq_data,
    input  logic           rdq_last,
    input  logic           order_ok,
    input  logic           alias_en,
    output logic           req_valid,
    output logic [AW-1:0]  req_addr,
    output logic [3:0]     req_cmd,
    output logic           req_par,
    output logic [BEW-1:0] req_be,
    output logic           retry,
    output logic           trdy,
    output logic           disc,
    output logic [DW-1:0]  dout,
    output logic           rdq_pop,
    output logic           rdq_flush
);
    logic     hit;
    logic     stage_en;
    logic     commit;
    logic     free_en;
    logic     cmd_is_read;
    logic     ready_all;
    cmd_tag_t in_tag;
    cmd_tag_t e_tag;

    always_comb begin
        in_tag.cmd  = cmd_in;
        in_tag.par  = par_in;
        cmd_is_read = is_read_cmd(cmd_in);
        ready_all   = cpl_done && rdq_head_ok && order_ok;
    end

    drt_entry #(.AW(AW), .BEW(BEW)) u_entry (
        .clk       (clk),
        .rst       (rst),
        .stage_en  (stage_en),
        .st_addr   (addr_in),
        .st_tag    (in_tag),
        .commit    (commit),
        .commit_be (be_in),
        .free_en   (free_en),
        .vld       (req_valid),
        .e_addr    (req_addr),
        .e_tag     (e_tag),
        .e_be      (req_be)
    );

    drt_cmd_match #(.AW(AW)) u_match (
        .entry_vld (req_valid),
        .e_addr    (req_addr),
        .e_cmd     (e_tag.cmd),
        .q_addr    (addr_in),
        .q_cmd     (cmd_in),
        .alias_en  (alias_en),
        .hit       (hit)
    );

    drt_bus_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .addr_valid  (addr_valid),
        .cmd_is_read (cmd_is_read),
        .entry_vld   (req_valid),
        .hit         (hit),
        .ready_all   (ready_all),
        .irdy        (irdy),
        .init_abort  (init_abort),
        .rdq_last    (rdq_last),
        .stage_en    (stage_en),
        .commit      (commit),
        .free_en     (free_en),
        .retry       (retry),
        .trdy        (trdy),
        .disc        (disc),
        .flush       (rdq_flush)
    );

    always_comb begin
        req_cmd = e_tag.cmd;
        req_par = e_tag.par;
        dout    = rdq_data;
        rdq_pop = trdy;
    end
endmodule

// File: rtl/drt_target_chk.sv
module drt_target_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          irdy,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [3:0]    req_cmd,
    input logic          retry,
    input logic          trdy,
    input logic          disc,
    input logic          rdq_flush
);
    // R3: a retry carries no data
    a_r3_retry_no_data: assert property (@(posedge clk) disable iff (rst)
        retry |-> !trdy);

    // R3: retry lasts a single cycle
    a_r3_retry_single: assert property (@(posedge clk) disable iff (rst)
        retry |=> !retry);

    // R2: the slot only fills on a cycle where the initiator was ready
    a_r2_commit_on_irdy: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(irdy));

    // R6: a disconnect empties the slot
    a_r6_disc_frees: assert property (@(posedge clk) disable iff (rst)
        disc |=> !req_valid);

    // R7: a flush empties the slot
    a_r7_flush_frees: assert property (@(posedge clk) disable iff (rst)
        rdq_flush |=> !req_valid);

    // R10: data moves only against a held request
    a_r10_trdy_needs_entry: assert property (@(posedge clk) disable iff (rst)
        trdy |-> req_valid);

    // R9: a held request stays intact until served or flushed
    a_r9_entry_held: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !disc && !rdq_flush) |=>
            (req_valid && $stable(req_addr) && $stable(req_cmd)));
endmodule

bind drt_target drt_target_chk #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .irdy      (irdy),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_cmd   (req_cmd),
    .retry     (retry),
    .trdy      (trdy),
    .disc      (disc),
    .rdq_flush (rdq_flush)
);

// File: tb/test_drt_target.sv
module test_drt_target;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int DW  = 64;
    localparam int BEW = DW / 8;
    localparam int NV  = 10;

    // {stored cmd, repeat cmd, alias, cpl, head, order, addr match, expect serve}
    localparam logic [13:0] VEC [NV] = '{
        {4'h6, 4'h6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'h6, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'h6, 4'h6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'h6, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'h6, 4'hC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'h6, 4'hC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'hE, 4'h6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'hE, 4'h6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'h6, 4'h6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'h2, 4'h2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           addr_valid = 1'b0;
    logic [AW-1:0]  addr_in = '0;
    logic [3:0]     cmd_in = '0;
    logic           par_in = 1'b0;
    logic           irdy = 1'b0;
    logic [BEW-1:0] be_in = '0;
    logic           init_abort = 1'b0;
    logic           cpl_done = 1'b0;
    logic           rdq_head_ok = 1'b0;
    logic [DW-1:0]  rdq_data = '0;
    logic           rdq_last = 1'b0;
    logic           order_ok = 1'b0;
    logic           alias_en = 1'b0;
    logic           req_valid;
    logic [AW-1:0]  req_addr;
    logic [3:0]     req_cmd;
    logic           req_par;
    logic [BEW-1:0] req_be;
    logic           retry;
    logic           trdy;
    logic           disc;
    logic [DW-1:0]  dout;
    logic           rdq_pop;
    logic           rdq_flush;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    drt_target #(.AW(AW), .DW(DW)) i_drt_target (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; addr_valid = 1'b0; irdy = 1'b0; init_abort = 1'b0; rdq_last = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic addr_phase(input logic [AW-1:0] a, input logic [3:0] c, input logic p);
        @(negedge clk);
        addr_valid = 1'b1; addr_in = a; cmd_in = c; par_in = p; irdy = 1'b0;
    endtask

    task automatic capture(input logic [AW-1:0] a, input logic [3:0] c, input logic p,
                           input logic [BEW-1:0] be);
        addr_phase(a, c, p);
        @(negedge clk);
        addr_valid = 1'b0; irdy = 1'b1; be_in = be;
        #1;
        chk("R3 no retry while taking byte enables", {63'd0, retry}, 64'd0);
        chk("R3 no trdy during capture", {63'd0, trdy}, 64'd0);
        @(negedge clk);
        irdy = 1'b0; be_in = '0;
        #1;
        chk("R3 retry after capture", {63'd0, retry}, 64'd1);
        chk("R2 slot valid", {63'd0, req_valid}, 64'd1);
        chk("R1 stored address", {48'd0, req_addr}, {48'd0, a});
        chk("R1 stored command", {60'd0, req_cmd}, {60'd0, c});
        chk("R1 stored parity", {63'd0, req_par}, {63'd0, p});
        chk("R2 stored byte enables", {56'd0, req_be}, {56'd0, be});
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state
        do_reset();
        #1;
        chk("R1 reset slot empty", {63'd0, req_valid}, 64'd0);
        chk("R3 reset no retry", {63'd0, retry}, 64'd0);
        chk("R10 reset no trdy", {63'd0, trdy}, 64'd0);

        // Vector table: serve-or-retry decisions (R4, R5, R8)
        for (int i = 0; i < NV; i++) begin
            logic [3:0]    sc;
            logic [3:0]    rc;
            logic          exp_hit;
            logic [AW-1:0] ra;
            sc = VEC[i][13:10];
            rc = VEC[i][9:6];
            exp_hit = VEC[i][0];
            do_reset();
            alias_en = VEC[i][5];
            capture(16'h1230, sc, 1'b1, 8'hA5);
            cpl_done = VEC[i][4]; rdq_head_ok = VEC[i][3]; order_ok = VEC[i][2];
            ra = VEC[i][1] ? 16'h1230 : 16'h1234;
            addr_phase(ra, rc, 1'b0);
            @(negedge clk);
            addr_valid = 1'b0; irdy = 1'b1; rdq_last = 1'b1; rdq_data = 64'hFEED_0000_0000_0000 + 64'(i);
            #1;
            chk($sformatf("R4 R5 R8 vec%0d served", i), {63'd0, trdy}, {63'd0, exp_hit});
            chk($sformatf("R4 R5 R8 vec%0d retry", i), {63'd0, retry}, {63'd0, !exp_hit});
            @(negedge clk);
            irdy = 1'b0; rdq_last = 1'b0;
            #1;
            chk($sformatf("R8 vec%0d slot after", i), {63'd0, req_valid}, {63'd0, !exp_hit});
            chk($sformatf("R8 vec%0d address kept", i), {48'd0, req_addr}, 64'h1230);
            cpl_done = 1'b0; rdq_head_ok = 1'b0; order_ok = 1'b0; alias_en = 1'b0;
        end

        // R10 / R6: streaming with a wait cycle and disconnect on the last word
        do_reset();
        capture(16'h0400, 4'h6, 1'b0, 8'h0F);
        cpl_done = 1'b1; rdq_head_ok = 1'b1; order_ok = 1'b1;
        addr_phase(16'h0400, 4'h6, 1'b0);
        @(negedge clk);
        addr_valid = 1'b0; irdy = 1'b1; rdq_data = 64'h1111; rdq_last = 1'b0;
        #1;
        chk("R10 first word trdy", {63'd0, trdy}, 64'd1);
        chk("R10 first word data", dout, 64'h1111);
        chk("R10 first word pop", {63'd0, rdq_pop}, 64'd1);
        chk("R6 no disc on first", {63'd0, disc}, 64'd0);
        @(negedge clk);
        irdy = 1'b0; rdq_data = 64'h2222;
        #1;
        chk("R10 wait cycle no trdy", {63'd0, trdy}, 64'd0);
        chk("R10 wait cycle no pop", {63'd0, rdq_pop}, 64'd0);
        @(negedge clk);
        irdy = 1'b1;
        #1;
        chk("R10 second word data", dout, 64'h2222);
        chk("R10 second word trdy", {63'd0, trdy}, 64'd1);
        @(negedge clk);
        rdq_data = 64'h3333; rdq_last = 1'b1;
        #1;
        chk("R6 disc with last word", {63'd0, disc}, 64'd1);
        chk("R6 last word trdy", {63'd0, trdy}, 64'd1);
        @(negedge clk);
        irdy = 1'b0; rdq_last = 1'b0;
        #1;
        chk("R6 slot freed after last", {63'd0, req_valid}, 64'd0);
        chk("R6 no trdy after end", {63'd0, trdy}, 64'd0);

        // R7: early termination flushes and frees the slot
        capture(16'h0800, 4'h6, 1'b1, 8'hFF);
        addr_phase(16'h0800, 4'h6, 1'b0);
        @(negedge clk);
        addr_valid = 1'b0; irdy = 1'b1; rdq_last = 1'b0;
        #1;
        chk("R7 streaming started", {63'd0, trdy}, 64'd1);
        @(negedge clk);
        irdy = 1'b0; init_abort = 1'b1;
        #1;
        chk("R7 flush on abort", {63'd0, rdq_flush}, 64'd1);
        @(negedge clk);
        init_abort = 1'b0;
        #1;
        chk("R7 slot freed", {63'd0, req_valid}, 64'd0);
        chk("R7 no flush after", {63'd0, rdq_flush}, 64'd0);

        // R9: a different read while the slot is full is retried, not captured
        capture(16'h0C00, 4'h6, 1'b0, 8'h01);
        addr_phase(16'h0D00, 4'hE, 1'b1);
        @(negedge clk);
        addr_valid = 1'b0; irdy = 1'b1;
        #1;
        chk("R9 other read retried", {63'd0, retry}, 64'd1);
        chk("R9 other read no trdy", {63'd0, trdy}, 64'd0);
        @(negedge clk);
        irdy = 1'b0;
        #1;
        chk("R9 address unchanged", {48'd0, req_addr}, 64'h0C00);
        chk("R9 command unchanged", {60'd0, req_cmd}, 64'h6);
        cpl_done = 1'b0; rdq_head_ok = 1'b0; order_ok = 1'b0;

        // R11: non-read command ignored
        do_reset();
        addr_phase(16'h0F00, 4'h7, 1'b0);
        @(negedge clk);
        addr_valid = 1'b0; irdy = 1'b1;
        #1;
        chk("R11 no retry on write", {63'd0, retry}, 64'd0);
        chk("R11 no trdy on write", {63'd0, trdy}, 64'd0);
        @(negedge clk);
        irdy = 1'b0;
        #1;
        chk("R11 no capture", {63'd0, req_valid}, 64'd0);
        chk("R11 still no retry", {63'd0, retry}, 64'd0);

        settle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule